// File: doc/BRIEF.md
# Paired-Page TLB Lookup

This block is a fully associative address translation cache. Each of its entries covers two neighbouring virtual pages of the same size, and each page maps to a physical frame of its own. A lookup presents a virtual address, the kind of access (instruction fetch, data load or data store) and the current 8-bit address-space identifier. One clock later the block returns either a physical address with a write-permission flag, or one of five status codes that say why the translation failed.

Software or a refill engine fills entries through an indexed write port, one entry per cycle, with every field given on its own input. A per-entry invalidate vector marks entries unusable without rewriting them. Choosing which entry to replace and walking page tables are handled elsewhere.

Page sizes run from 4 KB upwards in powers of four, set per entry by a page-size mask. A page pair is therefore at least 8 KB. The lowest 13 address bits never take part in the tag compare.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry is marked invalidated, `rsp_valid` is 0, and every lookup returns status 1 (no match) until an entry is written.
- R2: An entry hits when three conditions all hold. Its global bit is set or its stored ASID equals `cur_asid`. Its tag matches the address under its compare mask. Its invalidated mark is clear.
- R3: The compare mask of an entry is `wr_pmask` placed at address bit 13 and upward, ORed with ones in bits 12..0. Masked bits are ignored in the tag compare. The mask ones are contiguous from its bit 0, so `wr_pmask` values 0, 3, 15 and 63 select 4 KB, 16 KB, 64 KB and 256 KB pages.
- R4: The odd half is selected when the address bit at the top of the compare mask is 1; otherwise the even half is selected. On success `rsp_pa` is that half's frame address ORed with the address bits below that top mask bit.
- R5: The per-half flags are encoded as bit 0 valid, bit 1 dirty, bit 2 read-inhibit and bit 3 execute-inhibit. A hit on a half whose valid bit is 0 returns status 2 (invalid).
- R6: A fetch (`lk_acc`=0) from a half with execute-inhibit set returns status 3. A load (`lk_acc`=1, and 3 is treated as a load) from a half with read-inhibit set returns status 4. Execute-inhibit has no effect on loads and stores, and read-inhibit has no effect on fetches and stores.
- R7: A store (`lk_acc`=2) to a half whose dirty bit is 0 returns status 5 (modify).
- R8: When several faults apply, the first one in this order is reported: invalid, execute-inhibit, read-inhibit, modify.
- R9: Status 0 means success. On success `rsp_writable` equals the selected half's dirty bit. On any failure `rsp_writable` and `rsp_pa` are 0.
- R10: If no entry hits, the status is 1. If more than one entry hits, the lowest-index entry supplies the result.
- R11: A 1 in bit i of `inv_vec` marks entry i invalidated from the next cycle on. A write to an entry clears its mark.
- R12: `rsp_valid` and the response fields appear at the clock edge after the one that samples `lk_valid`=1; `rsp_valid` is 0 after a cycle without a lookup. A write and a lookup in the same cycle give a lookup that sees the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry to write |
| wr_vpn | input | VA_W | Virtual base of the page pair |
| wr_pmask | input | PM_W | Page-size mask above bit 13 |
| wr_asid | input | ASID_W | Address-space ID of the entry |
| wr_global | input | 1 | Entry matches any ASID |
| wr_pfn0 | input | PA_W | Frame address of the even half |
| wr_pfn1 | input | PA_W | Frame address of the odd half |
| wr_flg0 | input | 4 | Even half flags {xi, ri, dirty, valid} |
| wr_flg1 | input | 4 | Odd half flags {xi, ri, dirty, valid} |
| inv_vec | input | ENTRIES | Per-entry invalidate pulses |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| cur_asid | input | ASID_W | Current address-space ID |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | 0 ok, 1 no match, 2 invalid, 3 exec-inhibit, 4 read-inhibit, 5 modify |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_writable | output | 1 | Write permitted on this page |

## Verification
Every lookup result is due one edge after the edge that samples the request. The bench drives the request on a falling edge and reads all four outputs on the next falling edge, after the single registering edge. Writes and invalidates take effect at the edge that samples them, so a lookup issued in the following cycle sees them. The one exception is deliberately tested: a lookup presented in the same cycle as a write sees the old contents. The check on `rsp_valid` dropping is made one further cycle later.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_NOMATCH = 3'd1,
    ST_INVALID = 3'd2,
    ST_XINH    = 3'd3,
    ST_RINH    = 3'd4,
    ST_MODIFY  = 3'd5
  } tlb_status_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  typedef struct packed {
    logic xi;
    logic ri;
    logic d;
    logic v;
  } half_flags_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PM_W    = 16,
  parameter int ASID_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VA_W-1:0]     wr_vpn,
  input  logic [PM_W-1:0]     wr_pmask,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_global,
  input  logic [PA_W-1:0]     wr_pfn0,
  input  logic [PA_W-1:0]     wr_pfn1,
  input  half_flags_t         wr_flg0,
  input  half_flags_t         wr_flg1,
  input  logic [ENTRIES-1:0]  inv_vec,
  output logic [VA_W-1:0]     e_vpn   [ENTRIES],
  output logic [PM_W-1:0]     e_pmask [ENTRIES],
  output logic [ASID_W-1:0]   e_asid  [ENTRIES],
  output logic [ENTRIES-1:0]  e_glob,
  output logic [ENTRIES-1:0]  e_hinv,
  output logic [PA_W-1:0]     e_pfn0  [ENTRIES],
  output logic [PA_W-1:0]     e_pfn1  [ENTRIES],
  output half_flags_t         e_flg0  [ENTRIES],
  output half_flags_t         e_flg1  [ENTRIES]
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    // payload fields: no reset, plain enable-only registers
    always_ff @(posedge clk) begin
      if (sel) begin
        e_vpn[i]   <= wr_vpn;
        e_pmask[i] <= wr_pmask;
        e_asid[i]  <= wr_asid;
        e_pfn0[i]  <= wr_pfn0;
        e_pfn1[i]  <= wr_pfn1;
      end
    end

    // control bits: reset to an unusable entry
    always_ff @(posedge clk) begin
      if (rst) begin
        e_glob[i] <= 1'b0;
        e_hinv[i] <= 1'b1;
        e_flg0[i] <= '0;
        e_flg1[i] <= '0;
      end else begin
        if (sel) begin
          e_glob[i] <= wr_global;
          e_flg0[i] <= wr_flg0;
          e_flg1[i] <= wr_flg1;
        end
        if (inv_vec[i]) begin
          e_hinv[i] <= 1'b1;
        end else if (sel) begin
          e_hinv[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PM_W       = 16,
  parameter int ASID_W     = 8,
  parameter int PAIR_SHIFT = 13
) (
  input  logic [VA_W-1:0]    lk_va,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic [VA_W-1:0]    e_vpn   [ENTRIES],
  input  logic [PM_W-1:0]    e_pmask [ENTRIES],
  input  logic [ASID_W-1:0]  e_asid  [ENTRIES],
  input  logic [ENTRIES-1:0] e_glob,
  input  logic [ENTRIES-1:0] e_hinv,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] odd_vec
);

  localparam logic [VA_W-1:0] LOW_ONES = VA_W'((64'd1 << PAIR_SHIFT) - 64'd1);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VA_W-1:0] cmask;
    logic            id_ok;
    logic            tag_ok;

    assign cmask   = (VA_W'(e_pmask[i]) << PAIR_SHIFT) | LOW_ONES;
    assign id_ok   = e_glob[i] || (e_asid[i] == cur_asid);
    assign tag_ok  = ((lk_va ^ e_vpn[i]) & ~cmask) == '0;
    assign hit_vec[i] = id_ok && tag_ok && !e_hinv[i];
    assign odd_vec[i] = |(lk_va & cmask & ~(cmask >> 1));
  end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int IDX_W      = 4,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PM_W       = 16,
  parameter int PAIR_SHIFT = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [1:0]          lk_acc,
  input  logic [ENTRIES-1:0]  hit_vec,
  input  logic [ENTRIES-1:0]  odd_vec,
  input  logic [PM_W-1:0]     e_pmask [ENTRIES],
  input  logic [PA_W-1:0]     e_pfn0  [ENTRIES],
  input  logic [PA_W-1:0]     e_pfn1  [ENTRIES],
  input  half_flags_t         e_flg0  [ENTRIES],
  input  half_flags_t         e_flg1  [ENTRIES],
  output logic                rsp_valid,
  output logic [2:0]          rsp_status,
  output logic [PA_W-1:0]     rsp_pa,
  output logic                rsp_writable
);

  localparam logic [VA_W-1:0] LOW_ONES = VA_W'((64'd1 << PAIR_SHIFT) - 64'd1);

  logic [IDX_W-1:0] sel;
  logic             any_hit;
  logic             odd;
  half_flags_t      fl;
  logic [PA_W-1:0]  frame;
  logic [VA_W-1:0]  half_mask;
  tlb_status_e      st_n;
  logic [PA_W-1:0]  pa_n;
  logic             wr_n;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign odd       = odd_vec[sel];
  assign fl        = odd ? e_flg1[sel] : e_flg0[sel];
  assign frame     = odd ? e_pfn1[sel] : e_pfn0[sel];
  assign half_mask = ((VA_W'(e_pmask[sel]) << PAIR_SHIFT) | LOW_ONES) >> 1;

  always_comb begin
    st_n = ST_OK;
    pa_n = '0;
    wr_n = 1'b0;
    if (!any_hit) begin
      st_n = ST_NOMATCH;
    end else if (!fl.v) begin
      st_n = ST_INVALID;
    end else if (lk_acc == ACC_FETCH && fl.xi) begin
      st_n = ST_XINH;
    end else if (lk_acc != ACC_FETCH && lk_acc != ACC_STORE && fl.ri) begin
      st_n = ST_RINH;
    end else if (lk_acc == ACC_STORE && !fl.d) begin
      st_n = ST_MODIFY;
    end else begin
      pa_n = frame | PA_W'(lk_va & half_mask);
      wr_n = fl.d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= 3'(ST_NOMATCH);
      rsp_pa       <= '0;
      rsp_writable <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_status   <= 3'(st_n);
        rsp_pa       <= pa_n;
        rsp_writable <= wr_n;
      end
    end
  end

endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PM_W        = 16,
  parameter int ASID_W      = 8,
  parameter int OFFSET_BITS = 12,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int PAIR_SHIFT = OFFSET_BITS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VA_W-1:0]     wr_vpn,
  input  logic [PM_W-1:0]     wr_pmask,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_global,
  input  logic [PA_W-1:0]     wr_pfn0,
  input  logic [PA_W-1:0]     wr_pfn1,
  input  logic [3:0]          wr_flg0,
  input  logic [3:0]          wr_flg1,
  input  logic [ENTRIES-1:0]  inv_vec,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [1:0]          lk_acc,
  input  logic [ASID_W-1:0]   cur_asid,
  output logic                rsp_valid,
  output logic [2:0]          rsp_status,
  output logic [PA_W-1:0]     rsp_pa,
  output logic                rsp_writable
);

  logic [VA_W-1:0]    e_vpn   [ENTRIES];
  logic [PM_W-1:0]    e_pmask [ENTRIES];
  logic [ASID_W-1:0]  e_asid  [ENTRIES];
  logic [ENTRIES-1:0] e_glob;
  logic [ENTRIES-1:0] e_hinv;
  logic [PA_W-1:0]    e_pfn0  [ENTRIES];
  logic [PA_W-1:0]    e_pfn1  [ENTRIES];
  half_flags_t        e_flg0  [ENTRIES];
  half_flags_t        e_flg1  [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] odd_vec;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VA_W(VA_W), .PA_W(PA_W),
    .PM_W(PM_W), .ASID_W(ASID_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
    .wr_flg0(half_flags_t'(wr_flg0)), .wr_flg1(half_flags_t'(wr_flg1)),
    .inv_vec(inv_vec),
    .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid), .e_glob(e_glob),
    .e_hinv(e_hinv), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1),
    .e_flg0(e_flg0), .e_flg1(e_flg1)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PM_W(PM_W), .ASID_W(ASID_W),
    .PAIR_SHIFT(PAIR_SHIFT)
  ) u_match (
    .lk_va(lk_va), .cur_asid(cur_asid),
    .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid),
    .e_glob(e_glob), .e_hinv(e_hinv),
    .hit_vec(hit_vec), .odd_vec(odd_vec)
  );

  tlb_resolve #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VA_W(VA_W), .PA_W(PA_W),
    .PM_W(PM_W), .PAIR_SHIFT(PAIR_SHIFT)
  ) u_resolve (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc),
    .hit_vec(hit_vec), .odd_vec(odd_vec),
    .e_pmask(e_pmask), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1),
    .e_flg0(e_flg0), .e_flg1(e_flg1),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_pa(rsp_pa), .rsp_writable(rsp_writable)
  );

endmodule

// File: rtl/paired_tlb_chk.sv
module paired_tlb_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [1:0]      lk_acc,
  input logic            rsp_valid,
  input logic [2:0]      rsp_status,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_writable
);

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R9
  writable_only_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_writable) |-> (rsp_status == 3'd0));

  // R9
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != 3'd0) |-> (rsp_pa == '0));

  // R6
  store_no_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_acc == 2'd2) |=> (rsp_status != 3'd3 && rsp_status != 3'd4));

  // R6
  fetch_no_rinh_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_acc == 2'd0) |=> (rsp_status != 3'd4 && rsp_status != 3'd5));

  // R10
  status_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status <= 3'd5));

endmodule

bind paired_tlb paired_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_acc(lk_acc),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_pa(rsp_pa), .rsp_writable(rsp_writable)
);

// File: tb/tb_paired_tlb.sv
module tb_paired_tlb;

  localparam int ENT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0;
  logic [15:0] wr_pmask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [31:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic [3:0]  wr_flg0 = '0, wr_flg1 = '0;
  logic [ENT-1:0] inv_vec = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic [1:0]  lk_acc = '0;
  logic [7:0]  cur_asid = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_pa;
  logic        rsp_writable;

  int total = 0;
  int bad = 0;

  // bench-side table kept from what was written
  logic [31:0] sh_vpn [ENT];
  logic [15:0] sh_pm  [ENT];
  logic [7:0]  sh_asid[ENT];
  logic        sh_g   [ENT];
  logic        sh_inv [ENT];
  logic [31:0] sh_p0  [ENT];
  logic [31:0] sh_p1  [ENT];
  logic [3:0]  sh_f0  [ENT];
  logic [3:0]  sh_f1  [ENT];

  paired_tlb dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_flg0(wr_flg0), .wr_flg1(wr_flg1),
    .inv_vec(inv_vec), .lk_valid(lk_valid), .lk_va(lk_va), .lk_acc(lk_acc),
    .cur_asid(cur_asid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_pa(rsp_pa), .rsp_writable(rsp_writable)
  );

  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] cmask(input logic [15:0] pm);
    return (32'(pm) << 13) | 32'h1fff;
  endfunction

  // expected result from R2..R10
  task automatic model(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] asid,
                       output logic [2:0] st, output logic [31:0] pa, output logic wr);
    int w;
    logic [31:0] m;
    logic odd;
    logic [3:0] f;
    w = -1; st = 3'd1; pa = '0; wr = 1'b0;
    for (int i = ENT - 1; i >= 0; i--) begin
      m = cmask(sh_pm[i]);
      if ((sh_g[i] || sh_asid[i] == asid) && ((va & ~m) == (sh_vpn[i] & ~m)) && !sh_inv[i])
        w = i;
    end
    if (w >= 0) begin
      m = cmask(sh_pm[w]);
      odd = |(va & m & ~(m >> 1));
      f = odd ? sh_f1[w] : sh_f0[w];
      if (!f[0]) st = 3'd2;
      else if (acc == 2'd0 && f[3]) st = 3'd3;
      else if ((acc == 2'd1 || acc == 2'd3) && f[2]) st = 3'd4;
      else if (acc == 2'd2 && !f[1]) st = 3'd5;
      else begin
        st = 3'd0;
        pa = (odd ? sh_p1[w] : sh_p0[w]) | (va & (m >> 1));
        wr = f[1];
      end
    end
  endtask

  task automatic write_ent(input int idx, input logic [31:0] vpn, input logic [15:0] pm,
                           input logic [7:0] asid, input logic g, input logic [31:0] p0,
                           input logic [31:0] p1, input logic [3:0] f0, input logic [3:0] f1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
    wr_global = g; wr_pfn0 = p0; wr_pfn1 = p1; wr_flg0 = f0; wr_flg1 = f1;
    @(negedge clk);
    wr_en = 1'b0;
    sh_vpn[idx] = vpn; sh_pm[idx] = pm; sh_asid[idx] = asid; sh_g[idx] = g;
    sh_p0[idx] = p0; sh_p1[idx] = p1; sh_f0[idx] = f0; sh_f1[idx] = f1; sh_inv[idx] = 1'b0;
  endtask

  task automatic invalidate(input int idx);
    @(negedge clk);
    inv_vec = '0;
    inv_vec[idx] = 1'b1;
    @(negedge clk);
    inv_vec = '0;
    sh_inv[idx] = 1'b1;
  endtask

  // request on one falling edge, result registered at the rising edge, read on the next falling edge
  task automatic lookup_exp(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] asid,
                            input logic [2:0] est, input logic [31:0] epa, input logic ewr,
                            input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_acc = acc; cur_asid = asid;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({rq, " R12 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({rq, " status"}, 32'(rsp_status), 32'(est));
    chk({rq, " pa"}, rsp_pa, epa);
    chk({rq, " writable"}, 32'(rsp_writable), 32'(ewr));
  endtask

  task automatic lookup_cmp(input logic [31:0] va, input logic [1:0] acc, input logic [7:0] asid,
                            input string rq);
    logic [2:0] s;
    logic [31:0] p;
    logic w;
    model(va, acc, asid, s, p, w);
    lookup_exp(va, acc, asid, s, p, w, rq);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin
      sh_vpn[i] = '0; sh_pm[i] = '0; sh_asid[i] = '0; sh_g[i] = 1'b0; sh_inv[i] = 1'b1;
      sh_p0[i] = '0; sh_p1[i] = '0; sh_f0[i] = '0; sh_f1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    lookup_exp(32'h0000_0000, 2'd1, 8'd0, 3'd1, 32'd0, 1'b0, "R1 empty table");
    lookup_exp(32'h0120_3456, 2'd0, 8'd3, 3'd1, 32'd0, 1'b0, "R1 empty table fetch");
    @(negedge clk);
    chk("R12 rsp_valid drops", 32'(rsp_valid), 32'd0);

    // R12: a write in the same cycle as a lookup is not seen by that lookup
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_vpn = 32'h0300_0000; wr_pmask = '0; wr_asid = 8'd1;
    wr_global = 1'b0; wr_pfn0 = 32'h5000_0000; wr_pfn1 = 32'h5100_0000;
    wr_flg0 = 4'b0011; wr_flg1 = 4'b0011;
    lk_valid = 1'b1; lk_va = 32'h0300_0010; lk_acc = 2'd1; cur_asid = 8'd1;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R12 same-cycle write not seen", 32'(rsp_status), 32'd1);
    sh_vpn[7] = 32'h0300_0000; sh_pm[7] = '0; sh_asid[7] = 8'd1; sh_g[7] = 1'b0;
    sh_p0[7] = 32'h5000_0000; sh_p1[7] = 32'h5100_0000; sh_f0[7] = 4'b0011;
    sh_f1[7] = 4'b0011; sh_inv[7] = 1'b0;
    lookup_exp(32'h0300_0010, 2'd1, 8'd1, 3'd0, 32'h5000_0010, 1'b1, "R12 write seen next cycle");

    // fill all entries with varied page sizes, ASIDs, global bits and flags
    for (int i = 0; i < ENT; i++) begin
      logic [15:0] pm;
      pm = 16'((1 << ((i % 4) * 2)) - 1);
      write_ent(i, 32'h0100_0000 + 32'(i) * 32'h0010_0000, pm, 8'(i + 16), (i % 5) == 0,
                32'h4000_0000 + (32'(i) << 20), 32'h6000_0000 + (32'(i) << 20),
                4'((i * 7) % 16), 4'((i * 11 + 5) % 16));
    end

    // near-exhaustive sweep: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < ENT; i++) begin
      logic [31:0] pair;
      pair = cmask(sh_pm[i]) + 1;
      for (int k = 0; k < 10; k++) begin
        logic [31:0] va;
        va = sh_vpn[i] + 32'(k) * (pair >> 3) + 32'(k * 12);
        for (int a = 0; a < 4; a++) begin
          lookup_cmp(va, 2'(a), 8'(i + 16), "R4 R5 R6 R7 R9 sweep own ASID");
          lookup_cmp(va, 2'(a), 8'(i + 17), "R2 sweep other ASID");
        end
      end
    end

    // R3: with 16 KB pages a bit 13 change stays within the pair, bit 15 leaves it
    write_ent(2, 32'h0900_0000, 16'h0003, 8'd9, 1'b0, 32'h7000_0000, 32'h7800_0000,
              4'b0011, 4'b0011);
    lookup_exp(32'h0900_2abc, 2'd1, 8'd9, 3'd0, 32'h7000_2abc, 1'b1, "R3 bit13 inside even page");
    lookup_exp(32'h0900_6abc, 2'd1, 8'd9, 3'd0, 32'h7800_2abc, 1'b1, "R4 bit14 selects odd");
    lookup_exp(32'h0900_8000, 2'd1, 8'd9, 3'd1, 32'h0, 1'b0, "R3 bit15 outside pair");

    // R8: fault priority
    write_ent(4, 32'h0a00_0000, 16'h0000, 8'd2, 1'b0, 32'h1100_0000, 32'h1200_0000,
              4'b1101, 4'b1110);
    lookup_exp(32'h0a00_1004, 2'd0, 8'd2, 3'd2, 32'h0, 1'b0, "R8 invalid before xi");
    lookup_exp(32'h0a00_1004, 2'd2, 8'd2, 3'd2, 32'h0, 1'b0, "R8 invalid before modify");
    lookup_exp(32'h0a00_0004, 2'd0, 8'd2, 3'd3, 32'h0, 1'b0, "R8 xi before modify");
    lookup_exp(32'h0a00_0004, 2'd1, 8'd2, 3'd4, 32'h0, 1'b0, "R8 ri on load");
    lookup_exp(32'h0a00_0004, 2'd2, 8'd2, 3'd5, 32'h0, 1'b0, "R7 modify on clean store");
    write_ent(4, 32'h0a00_0000, 16'h0000, 8'd2, 1'b0, 32'h1100_0000, 32'h1200_0000,
              4'b1111, 4'b1110);
    lookup_exp(32'h0a00_0004, 2'd2, 8'd2, 3'd0, 32'h1100_0004, 1'b1, "R6 inhibits ignored on store");

    // R10 and R11: lowest index wins, invalidate and rewrite
    write_ent(3, 32'h0b00_0000, 16'h0000, 8'd0, 1'b1, 32'h2100_0000, 32'h2200_0000,
              4'b0011, 4'b0001);
    write_ent(9, 32'h0b00_0000, 16'h0000, 8'd0, 1'b1, 32'h3100_0000, 32'h3200_0000,
              4'b0001, 4'b0011);
    lookup_exp(32'h0b00_0123, 2'd1, 8'd77, 3'd0, 32'h2100_0123, 1'b1, "R10 lowest index wins");
    lookup_exp(32'h0b00_1123, 2'd1, 8'd77, 3'd0, 32'h2200_0123, 1'b0, "R9 clean half not writable");
    invalidate(3);
    lookup_exp(32'h0b00_0123, 2'd1, 8'd77, 3'd0, 32'h3100_0123, 1'b0, "R11 invalidated entry skipped");
    invalidate(9);
    lookup_exp(32'h0b00_0123, 2'd1, 8'd77, 3'd1, 32'h0, 1'b0, "R10 no entry hits");
    write_ent(3, 32'h0b00_0000, 16'h0000, 8'd0, 1'b1, 32'h2100_0000, 32'h2200_0000,
              4'b0011, 4'b0001);
    lookup_exp(32'h0b00_0123, 2'd2, 8'd77, 3'd0, 32'h2100_0123, 1'b1, "R11 write clears mark");

    @(negedge clk);
    chk("R12 idle after lookups", 32'(rsp_valid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule